// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptance Unit

This block sits between a bank of interrupt request lines and a processor core. Each maskable source carries a 3-bit priority level set through a configuration input. A separate non-maskable source is always taken. The unit holds a 3-bit interrupt mask, a nesting counter and a small stack of saved masks. Whenever no entry sequence is running, it raises `irq_o` for the best eligible pending request. When the core acknowledges, the unit does five things in one clock edge:

- it captures the winning vector;
- it clears that source's pending bit;
- it raises the mask to the accepted level plus one, saturating at 7;
- it pushes the previous mask onto the save stack;
- it increments the nesting counter.

After an acceptance, a fixed entry window of `ENTRY_CYCLES` clocks follows. During that window no request is offered. Requests that arrive during the window stay pending and are judged once it closes.

A return strobe pops the saved mask back and decrements the nesting counter. The core can also load the mask directly, as an enable or disable instruction would. The handler entry address is the captured vector added to the base 0xFFFF00, so every handler entry lies in the 256 bytes from 0xFFFF00 to 0xFFFFFF.

Source `i` (0-based) has vector 0x10 + 4*i. The non-maskable source has vector 0x08.

Top module: `prio_irq_accept`

## Requirements
- R1: After reset the outputs take these values: `mask_o` = 7, `nest_o` = 0, `irq_o` = 0, `vec_o` = 0x00 and `entry_addr_o` = 0xFFFF00.
- R2: A maskable source is eligible only if all three hold: it is pending, its level (bits [3i+2:3i] of `level_cfg_i`) is in 1..6, and its level is >= `mask_o`. Level 0 or level 7 disables the source, and with the mask at 7 no maskable source is taken.
- R3: Among eligible requests, the highest level is accepted.
- R4: Among eligible requests at the same level, the smallest vector is accepted. Source `i` has vector 0x10 + 4*i, and the non-maskable source has vector 0x08.
- R5: On acceptance, `mask_o` becomes the accepted level plus one, except that it stays 7 when the accepted level is 7.
- R6: Acceptance clears only the accepted source's pending request. Other pending requests stay and are offered later.
- R7: Each acceptance increments `nest_o`, which saturates at 2^NEST_W - 1 (15 by default).
- R8: With `nest_o` > 0, a `reti_i` pulse restores the mask that was in force before the most recent unreturned acceptance, and decrements `nest_o`. A `reti_i` pulse with `nest_o` = 0 changes neither `mask_o` nor `nest_o`.
- R9: `entry_addr_o` equals 0xFFFF00 + `vec_o`.
- R10: The non-maskable request is accepted whatever the mask, at level 7, and leaves the mask at 7.
- R11: For `ENTRY_CYCLES` (default 3) clocks after an acceptance, `irq_o` stays low. A request that became pending in that window is offered once the window ends.
- R12: `ack_i` while `irq_o` is low has no effect, and `vec_o` changes only on an acceptance.
- R13: A `mask_wr_i` pulse loads `mask_wdata_i` into the mask. Acceptance and return take precedence in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Maskable request pulses, sets pending bits |
| nmi_i | input | 1 | Non-maskable request pulse |
| level_cfg_i | input | 3*NUM_SRC | Priority level per source, 3 bits each |
| ack_i | input | 1 | Core acknowledge of the offered request |
| reti_i | input | 1 | Return-from-interrupt strobe |
| mask_wr_i | input | 1 | Direct mask load strobe |
| mask_wdata_i | input | 3 | Value for direct mask load |
| irq_o | output | 1 | An eligible request is offered |
| vec_o | output | 8 | Vector of the last accepted request |
| entry_addr_o | output | 24 | Handler entry address |
| mask_o | output | 3 | Current interrupt mask |
| nest_o | output | NEST_W | Interrupt nesting count |

## Verification
A table of single-shot patterns pairs mask values with request sets and levels. The patterns separate four cases:

- one source accepted;
- a higher level beating a lower one;
- an equal-level tie resolved by vector;
- a request refused because its level is below the mask, zero, or seven.

Each accepting row also shows the mask rise, including the saturation from level 6 and from the non-maskable source. Directed sequences cover the rest. One keeps a second request pending through the entry window, to show it is held back and then offered. Another nests two acceptances and unwinds them with returns, to show the stack order. A third repeats non-maskable acceptances past the counter limit, and the same sequences also show a return at zero being ignored.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int          LVL_W      = 3;
  localparam logic [2:0]  LVL_TOP    = 3'd7;
  localparam logic [7:0]  NMI_VEC    = 8'h08;
  localparam logic [7:0]  VEC_BASE   = 8'h10;
  localparam logic [23:0] ENTRY_BASE = 24'hFFFF00;

  // vector assigned to maskable source idx
  function automatic logic [7:0] src_vector(input int idx);
    return VEC_BASE + 8'(idx * 4);
  endfunction

  // mask value after accepting a request of the given level
  function automatic logic [2:0] raise_mask(input logic [2:0] lvl);
    return (lvl == LVL_TOP) ? LVL_TOP : lvl + 3'd1;
  endfunction
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:0]         pend_i,   // bit NUM_SRC is the non-maskable source
  input  logic [NUM_SRC*LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0]         mask_i,
  output logic                     valid_o,
  output logic [LVL_W-1:0]         level_o,
  output logic [7:0]               vec_o,
  output logic [NUM_SRC:0]         grant_o
);
  logic             best_v;
  logic [LVL_W-1:0] best_l;
  logic [IDX_W-1:0] best_i;
  logic [LVL_W-1:0] lv;

  always_comb begin
    best_v = pend_i[NUM_SRC];
    best_l = LVL_TOP;
    best_i = IDX_W'(NUM_SRC);
    lv     = '0;
    // ascending scan with strict compare keeps the lowest index on a tie
    for (int i = 0; i < NUM_SRC; i++) begin
      lv = level_i[i*LVL_W +: LVL_W];
      if (pend_i[i] && lv != '0 && lv != LVL_TOP && lv >= mask_i &&
          (!best_v || lv > best_l)) begin
        best_v = 1'b1;
        best_l = lv;
        best_i = IDX_W'(i);
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (best_v) grant_o[best_i] = 1'b1;
    vec_o   = (best_i == IDX_W'(NUM_SRC)) ? NMI_VEC : src_vector(int'(best_i));
  end

  assign valid_o = best_v;
  assign level_o = best_l;
endmodule

// File: rtl/irq_mask_nest.sv
module irq_mask_nest
  import prio_irq_pkg::*;
#(
  parameter int NEST_W       = 4,
  parameter int ENTRY_CYCLES = 3,
  localparam int NEST_MAX    = (1 << NEST_W) - 1,
  localparam int CNT_W       = $clog2(ENTRY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [LVL_W-1:0]  acc_level_i,
  input  logic              ret_i,
  input  logic              wr_i,
  input  logic [LVL_W-1:0]  wdata_i,
  output logic [LVL_W-1:0]  mask_o,
  output logic [NEST_W-1:0] nest_o,
  output logic              busy_o
);
  logic [LVL_W-1:0]  mask_q, mask_d;
  logic [NEST_W-1:0] nest_q, nest_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push;
  logic [LVL_W-1:0]  stk [NEST_MAX];

  always_comb begin
    mask_d = mask_q;
    nest_d = nest_q;
    push   = 1'b0;
    cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    if (accept_i) begin
      mask_d = raise_mask(acc_level_i);
      cnt_d  = CNT_W'(ENTRY_CYCLES);
      if (nest_q != NEST_W'(NEST_MAX)) begin
        nest_d = nest_q + 1'b1;
        push   = 1'b1;
      end
    end else if (ret_i && nest_q != '0) begin
      mask_d = stk[nest_q - 1'b1];
      nest_d = nest_q - 1'b1;
    end else if (wr_i) begin
      mask_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= LVL_TOP;
      nest_q <= '0;
      cnt_q  <= '0;
    end else begin
      mask_q <= mask_d;
      nest_q <= nest_d;
      cnt_q  <= cnt_d;
    end
  end

  // save stack, written only under push enable
  always_ff @(posedge clk) begin
    if (push) stk[nest_q] <= mask_q;
  end

  assign mask_o = mask_q;
  assign nest_o = nest_q;
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/prio_irq_accept.sv
module prio_irq_accept
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int NEST_W       = 4,
  parameter int ENTRY_CYCLES = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic                     nmi_i,
  input  logic [NUM_SRC*LVL_W-1:0] level_cfg_i,
  input  logic                     ack_i,
  input  logic                     reti_i,
  input  logic                     mask_wr_i,
  input  logic [LVL_W-1:0]         mask_wdata_i,
  output logic                     irq_o,
  output logic [7:0]               vec_o,
  output logic [23:0]              entry_addr_o,
  output logic [LVL_W-1:0]         mask_o,
  output logic [NEST_W-1:0]        nest_o
);
  logic [NUM_SRC:0] pend, grant, clr;
  logic             win_v, busy, accept;
  logic [LVL_W-1:0] win_l, mask;
  logic [7:0]       win_vec;
  logic [7:0]       vec_q, vec_d;

  irq_pending_bank #(.N(NUM_SRC + 1)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  ({nmi_i, req_i}),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i  (pend),
    .level_i (level_cfg_i),
    .mask_i  (mask),
    .valid_o (win_v),
    .level_o (win_l),
    .vec_o   (win_vec),
    .grant_o (grant)
  );

  irq_mask_nest #(.NEST_W(NEST_W), .ENTRY_CYCLES(ENTRY_CYCLES)) u_mn (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .acc_level_i (win_l),
    .ret_i       (reti_i),
    .wr_i        (mask_wr_i),
    .wdata_i     (mask_wdata_i),
    .mask_o      (mask),
    .nest_o      (nest_o),
    .busy_o      (busy)
  );

  assign irq_o  = win_v & ~busy;
  assign accept = ack_i & irq_o;
  assign clr    = accept ? grant : '0;

  always_comb begin
    vec_d = accept ? win_vec : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= vec_d;
  end

  assign vec_o        = vec_q;
  assign entry_addr_o = ENTRY_BASE + {16'h0000, vec_q};
  assign mask_o       = mask;
endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker #(
  parameter int NEST_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_i,
  input logic              reti_i,
  input logic              mask_wr_i,
  input logic              irq_o,
  input logic [7:0]        vec_o,
  input logic [2:0]        mask_o,
  input logic [NEST_W-1:0] nest_o
);
  localparam logic [NEST_W-1:0] NMAX = '1;

  AST_QUIET_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> !irq_o); // R11

  AST_NEST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && nest_o != NMAX) |=> nest_o == NEST_W'($past(nest_o) + 1'b1)); // R7

  AST_NMI_MASK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> (vec_o != 8'h08 || mask_o == 3'd7)); // R10

  AST_RETURN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !mask_wr_i && !(ack_i && irq_o) && nest_o == '0) |=> (nest_o == '0 && $stable(mask_o))); // R8

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_i && irq_o) |=> $stable(vec_o)); // R12
endmodule

bind prio_irq_accept irq_accept_checker #(.NEST_W(NEST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack_i     (ack_i),
  .reti_i    (reti_i),
  .mask_wr_i (mask_wr_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .mask_o    (mask_o),
  .nest_o    (nest_o)
);

// File: tb/prio_irq_accept_test.sv
module prio_irq_accept_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {mask[47:45], req[44:37], nmi[36], levels[35:12], exp_irq[11], exp_vec[10:3], exp_mask[2:0]}
  localparam logic [47:0] TBL [NV] = '{
    {3'd1, 8'h01, 1'b0, 24'o00000003, 1'b1, 8'h10, 3'd4},  // R2 single source
    {3'd1, 8'h06, 1'b0, 24'o00000520, 1'b1, 8'h18, 3'd6},  // R3 higher level wins
    {3'd1, 8'h0C, 1'b0, 24'o00004400, 1'b1, 8'h18, 3'd5},  // R4 tie, lower vector
    {3'd4, 8'h01, 1'b0, 24'o00000003, 1'b0, 8'h00, 3'd4},  // R2 below mask
    {3'd4, 8'h80, 1'b0, 24'o40000000, 1'b1, 8'h2C, 3'd5},  // R2 equal to mask
    {3'd1, 8'h01, 1'b0, 24'o00000000, 1'b0, 8'h00, 3'd1},  // R2 level 0 disabled
    {3'd1, 8'h01, 1'b0, 24'o00000007, 1'b0, 8'h00, 3'd1},  // R2 level 7 disabled
    {3'd7, 8'h01, 1'b1, 24'o00000006, 1'b1, 8'h08, 3'd7},  // R10 nmi under mask 7
    {3'd1, 8'h30, 1'b0, 24'o00660000, 1'b1, 8'h20, 3'd7},  // R5 6+1 saturates
    {3'd0, 8'h01, 1'b0, 24'o00000001, 1'b1, 8'h10, 3'd2},  // R5 level 1
    {3'd7, 8'h01, 1'b0, 24'o00000006, 1'b0, 8'h00, 3'd7}   // R2 mask 7 blocks
  };

  logic        clk, rst_n;
  logic [7:0]  req_i;
  logic        nmi_i, ack_i, reti_i, mask_wr_i;
  logic [23:0] level_cfg_i;
  logic [2:0]  mask_wdata_i;
  logic        irq_o;
  logic [7:0]  vec_o;
  logic [23:0] entry_addr_o;
  logic [2:0]  mask_o;
  logic [3:0]  nest_o;
  int          checks, errors;
  bit          done;

  prio_irq_accept uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .nmi_i(nmi_i), .level_cfg_i(level_cfg_i),
    .ack_i(ack_i), .reti_i(reti_i), .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
    .irq_o(irq_o), .vec_o(vec_o), .entry_addr_o(entry_addr_o), .mask_o(mask_o), .nest_o(nest_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_i = '0; nmi_i = 0; ack_i = 0; reti_i = 0; mask_wr_i = 0;
    mask_wdata_i = '0; level_cfg_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    do_reset();
    @(negedge clk);
    chk("R1 mask", 32'(mask_o), 32'd7);
    chk("R1 nest", 32'(nest_o), 32'd0);
    chk("R1 irq", 32'(irq_o), 32'd0);
    chk("R1 vec", 32'(vec_o), 32'h00);
    chk("R1 entry", 32'(entry_addr_o), 32'hFFFF00);

    for (int k = 0; k < NV; k++) begin
      do_reset();
      @(negedge clk);
      mask_wr_i = 1; mask_wdata_i = TBL[k][47:45]; req_i = TBL[k][44:37];
      nmi_i = TBL[k][36]; level_cfg_i = TBL[k][35:12];
      @(negedge clk);
      mask_wr_i = 0; req_i = '0; nmi_i = 0;
      chk($sformatf("R2 table %0d irq", k), 32'(irq_o), 32'(TBL[k][11]));
      ack_i = 1;
      @(negedge clk);
      ack_i = 0;
      if (TBL[k][11]) begin
        chk($sformatf("R4 table %0d vec", k), 32'(vec_o), 32'(TBL[k][10:3]));
        chk($sformatf("R9 table %0d entry", k), 32'(entry_addr_o), 32'h00FFFF00 + 32'(TBL[k][10:3]));
        chk($sformatf("R5 table %0d mask", k), 32'(mask_o), 32'(TBL[k][2:0]));
        chk($sformatf("R7 table %0d nest", k), 32'(nest_o), 32'd1);
      end else begin
        chk($sformatf("R12 table %0d vec", k), 32'(vec_o), 32'h00);
        chk($sformatf("R12 table %0d mask", k), 32'(mask_o), 32'(TBL[k][2:0]));
        chk($sformatf("R12 table %0d nest", k), 32'(nest_o), 32'd0);
      end
    end

    // R13 direct mask load
    do_reset();
    @(negedge clk); mask_wr_i = 1; mask_wdata_i = 3'd5;
    @(negedge clk); mask_wr_i = 0;
    chk("R13 mask load", 32'(mask_o), 32'd5);

    // R6 / R11: second request held through the entry window
    do_reset();
    @(negedge clk);
    mask_wr_i = 1; mask_wdata_i = 3'd1; level_cfg_i = 24'o00000055; req_i = 8'h03;
    @(negedge clk);
    mask_wr_i = 0; req_i = '0;
    chk("R11 irq offered", 32'(irq_o), 32'd1);
    ack_i = 1;
    @(negedge clk);
    ack_i = 0;
    chk("R4 first vec", 32'(vec_o), 32'h10);
    chk("R11 quiet 1", 32'(irq_o), 32'd0);
    reti_i = 1;
    @(negedge clk);
    reti_i = 0;
    chk("R8 mask restored", 32'(mask_o), 32'd1);
    chk("R8 nest back", 32'(nest_o), 32'd0);
    chk("R11 quiet 2", 32'(irq_o), 32'd0);
    @(negedge clk);
    chk("R11 quiet 3", 32'(irq_o), 32'd0);
    @(negedge clk);
    chk("R11 offered after window", 32'(irq_o), 32'd1);
    ack_i = 1;
    @(negedge clk);
    ack_i = 0;
    chk("R6 second source vec", 32'(vec_o), 32'h14);
    reti_i = 1;
    @(negedge clk);
    reti_i = 0;
    repeat (2) @(negedge clk);
    chk("R6 nothing left", 32'(irq_o), 32'd0);

    // R8 nested restore order and return at zero
    do_reset();
    @(negedge clk);
    mask_wr_i = 1; mask_wdata_i = 3'd1; level_cfg_i = 24'o00000052; req_i = 8'h01;
    @(negedge clk);
    mask_wr_i = 0; req_i = '0; ack_i = 1;
    @(negedge clk);
    ack_i = 0; req_i = 8'h02;
    chk("R5 nested first mask", 32'(mask_o), 32'd3);
    @(negedge clk);
    req_i = '0;
    repeat (2) @(negedge clk);
    ack_i = 1;
    @(negedge clk);
    ack_i = 0;
    chk("R3 nested vec", 32'(vec_o), 32'h14);
    chk("R5 nested mask", 32'(mask_o), 32'd6);
    chk("R7 nested count", 32'(nest_o), 32'd2);
    reti_i = 1;
    @(negedge clk);
    reti_i = 0;
    chk("R8 pop one mask", 32'(mask_o), 32'd3);
    chk("R8 pop one nest", 32'(nest_o), 32'd1);
    reti_i = 1;
    @(negedge clk);
    reti_i = 0;
    chk("R8 pop two mask", 32'(mask_o), 32'd1);
    chk("R8 pop two nest", 32'(nest_o), 32'd0);
    reti_i = 1;
    @(negedge clk);
    reti_i = 0;
    chk("R8 zero ignored mask", 32'(mask_o), 32'd1);
    chk("R8 zero ignored nest", 32'(nest_o), 32'd0);

    // R7 / R10 saturation through repeated non-maskable entries
    do_reset();
    @(negedge clk);
    for (int n = 0; n < 16; n++) begin
      nmi_i = 1;
      @(negedge clk); nmi_i = 0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk); ack_i = 1;
      @(negedge clk); ack_i = 0;
      if (n == 14) chk("R7 count at max", 32'(nest_o), 32'd15);
    end
    chk("R7 count saturated", 32'(nest_o), 32'd15);
    chk("R10 nmi mask", 32'(mask_o), 32'd7);
    chk("R10 nmi vec", 32'(vec_o), 32'h08);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule